// File: doc/BRIEF.md
# Bus Idle Request and Cascade Arbiter

This block asks the host bridge to quiesce a shared PCI-style bus before a hot-plug slot is attached. It raises an active-low idle request toward the bridge and watches the returned active-low idle grant. Once the grant is held and the bus shows no transaction (FRAME and IRDY both inactive), it sends a single-cycle connect permit to the local slot sequencing logic. It then holds the request until that logic reports the connection is finished.

A second controller of the same kind can be cascaded behind this one. Its active-low request is forwarded upstream as this block's own idle request. Once the bridge grants, the grant is passed down on an active-low secondary grant output. The secondary controller does its own idle check on the bus. Only one requester is served per handshake. A local request wins over a secondary request that arrives in the same cycle. Everything runs on the bus clock, with an asynchronous active-low bus reset.

Top module: `bus_idle_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released with no request present, idle_req_n and sec_gnt_n are 1 and connect_ok is 0.
- R2: When no handshake is in progress, local_req at 1 on a clock edge drives idle_req_n to 0 from that edge on.
- R3: connect_ok goes to 1 only in the cycle after an edge where a local handshake was waiting and idle_gnt_n was 0 while frame_n and irdy_n were both 1.
- R4: connect_ok is 1 for exactly one cycle per local handshake.
- R5: During a local wait, an edge with idle_gnt_n at 1, or with frame_n or irdy_n at 0, produces no connect_ok pulse, and idle_req_n stays 0.
- R6: When no handshake is in progress and local_req is 0, sec_req_n at 0 on an edge drives idle_req_n to 0 from that edge on.
- R7: sec_req_n held at 1 with local_req at 0 never produces a request: idle_req_n and sec_gnt_n stay 1.
- R8: While a secondary handshake is in progress, sec_gnt_n goes to 0 on the first edge where idle_gnt_n is 0, and never goes to 0 without an earlier grant.
- R9: When local_req is 1 and sec_req_n is 0 on the same idle edge, the local request is served first. sec_gnt_n stays 1 until that handshake ends, and the secondary is served in a later handshake.
- R10: After connect_ok, local_done at 1 on an edge ends the local handshake: idle_req_n returns to 1 after that edge.
- R11: sec_req_n at 1 on an edge makes sec_gnt_n 1 and, if a secondary handshake was in progress, idle_req_n 1 after that edge.
- R12: connect_ok is never 1 while sec_gnt_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| local_req | input | 1 | Local slot connection pending |
| local_done | input | 1 | Local slot connection finished |
| sec_req_n | input | 1 | Cascaded controller request, active low |
| idle_gnt_n | input | 1 | Idle grant from host bridge, active low |
| frame_n | input | 1 | Bus FRAME line, active low |
| irdy_n | input | 1 | Bus IRDY line, active low |
| idle_req_n | output | 1 | Idle request to host bridge, active low |
| sec_gnt_n | output | 1 | Grant passed to cascaded controller, active low |
| connect_ok | output | 1 | One-cycle connect permit to local sequencing |

## Verification
The local request and the secondary request can arrive on the same clock edge. Arbitration has to pick the local side and keep the forwarded grant off while the local connect permit fires. The bench provokes this directly by lowering sec_req_n in the cycle where local_req rises, with idle_gnt_n already low. It checks that connect_ok pulses while sec_gnt_n stays high, and that the secondary grant appears only after local_done and a fresh handshake. Random phases then mix both requesters with a flickering grant and a busy bus, and every output is compared cycle by cycle against a behavioural model kept in the bench.

// File: rtl/bia_pkg.sv
package bia_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LWAIT  = 3'd1,
    ST_LHOLD  = 3'd2,
    ST_SWAIT  = 3'd3,
    ST_SGRANT = 3'd4
  } bia_state_t;

  // Bus is quiet once the grant is held and no transaction is active.
  function automatic logic bus_quiet(input logic gnt_n, input logic frm_n, input logic rdy_n);
    return (!gnt_n) && frm_n && rdy_n;
  endfunction

  function automatic logic in_handshake(input bia_state_t s);
    return s != ST_IDLE;
  endfunction

endpackage

// File: rtl/bia_idle_detect.sv
module bia_idle_detect (
  input  logic idle_gnt_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic grant_held,
  output logic quiet
);
  import bia_pkg::*;

  always_comb begin
    grant_held = !idle_gnt_n;
    quiet      = bus_quiet(idle_gnt_n, frame_n, irdy_n);
  end

endmodule

// File: rtl/bia_serve_fsm.sv
module bia_serve_fsm
  import bia_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       local_req,
  input  logic       local_done,
  input  logic       sec_req_n,
  input  logic       grant_held,
  input  logic       quiet,
  output bia_state_t state,
  output logic       start_local,
  output logic       start_sec,
  output logic       idle_hit
);

  bia_state_t state_nx;

  always_comb begin
    start_local = (state == ST_IDLE) && local_req;
    start_sec   = (state == ST_IDLE) && !local_req && !sec_req_n;
    idle_hit    = (state == ST_LWAIT) && quiet;
    state_nx    = state;
    unique case (state)
      ST_IDLE: begin
        if (start_local)    state_nx = ST_LWAIT;
        else if (start_sec) state_nx = ST_SWAIT;
      end
      ST_LWAIT:  if (idle_hit) state_nx = ST_LHOLD;
      ST_LHOLD:  if (local_done) state_nx = ST_IDLE;
      ST_SWAIT: begin
        if (sec_req_n)       state_nx = ST_IDLE;
        else if (grant_held) state_nx = ST_SGRANT;
      end
      ST_SGRANT: if (sec_req_n) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/bia_out_stage.sv
module bia_out_stage
  import bia_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bia_state_t state,
  input  logic       idle_hit,
  output logic       idle_req_n,
  output logic       sec_gnt_n,
  output logic       connect_ok
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) connect_ok <= 1'b0;
    else        connect_ok <= idle_hit;
  end

  always_comb begin
    idle_req_n = !in_handshake(state);
    sec_gnt_n  = (state != ST_SGRANT);
  end

endmodule

// File: rtl/bus_idle_arbiter.sv
module bus_idle_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic local_req,
  input  logic local_done,
  input  logic sec_req_n,
  input  logic idle_gnt_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic idle_req_n,
  output logic sec_gnt_n,
  output logic connect_ok
);
  import bia_pkg::*;

  logic       grant_held;
  logic       quiet;
  logic       start_local;
  logic       start_sec;
  logic       idle_hit;
  bia_state_t state;

  bia_idle_detect u_det (
    .idle_gnt_n (idle_gnt_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .grant_held (grant_held),
    .quiet      (quiet)
  );

  bia_serve_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .local_req   (local_req),
    .local_done  (local_done),
    .sec_req_n   (sec_req_n),
    .grant_held  (grant_held),
    .quiet       (quiet),
    .state       (state),
    .start_local (start_local),
    .start_sec   (start_sec),
    .idle_hit    (idle_hit)
  );

  bia_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .idle_hit   (idle_hit),
    .idle_req_n (idle_req_n),
    .sec_gnt_n  (sec_gnt_n),
    .connect_ok (connect_ok)
  );

endmodule

// File: rtl/bia_checker.sv
module bia_checker (
  input logic clk,
  input logic rst_n,
  input logic local_req,
  input logic local_done,
  input logic sec_req_n,
  input logic idle_gnt_n,
  input logic frame_n,
  input logic irdy_n,
  input logic idle_req_n,
  input logic sec_gnt_n,
  input logic connect_ok,
  input logic start_local,
  input logic start_sec
);

  a_r2_local_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req_n && local_req) |=> !idle_req_n);

  a_r3_permit_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect_ok) |-> $past(!idle_gnt_n && frame_n && irdy_n));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    connect_ok |=> !connect_ok);

  a_r6_sec_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req_n && !local_req && !sec_req_n) |=> !idle_req_n);

  a_r7_high_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req_n && !local_req && sec_req_n) |=> (idle_req_n && sec_gnt_n));

  a_r8_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_gnt_n) |-> ($past(!idle_gnt_n) && !idle_req_n));

  a_r9_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_local && start_sec));

  a_r11_sgnt_drop: assert property (@(posedge clk) disable iff (!rst_n)
    sec_req_n |=> sec_gnt_n);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(connect_ok && !sec_gnt_n));

endmodule

bind bus_idle_arbiter bia_checker u_chk (.*);

// File: tb/test_bus_idle_arbiter.sv
module test_bus_idle_arbiter;

  logic clk = 1'b0;
  logic rst_n;
  logic local_req, local_done, sec_req_n, idle_gnt_n, frame_n, irdy_n;
  logic idle_req_n, sec_gnt_n, connect_ok;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the handshake
  bit m_active, m_sec, m_perm, m_gnt, m_pulse;

  always #5 clk = ~clk;

  bus_idle_arbiter i_bus_idle_arbiter (
    .clk(clk), .rst_n(rst_n), .local_req(local_req), .local_done(local_done),
    .sec_req_n(sec_req_n), .idle_gnt_n(idle_gnt_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .idle_req_n(idle_req_n), .sec_gnt_n(sec_gnt_n),
    .connect_ok(connect_ok)
  );

  function automatic logic [2:0] expect_outs();
    return {!m_active, !(m_active && m_sec && m_gnt), m_pulse};
  endfunction

  task automatic model_reset();
    m_active = 0; m_sec = 0; m_perm = 0; m_gnt = 0; m_pulse = 0;
  endtask

  task automatic model_edge();
    bit quiet_now;
    quiet_now = !idle_gnt_n && frame_n && irdy_n;
    m_pulse = 0;
    if (!m_active) begin
      if (local_req) begin m_active = 1; m_sec = 0; m_perm = 0; end
      else if (!sec_req_n) begin m_active = 1; m_sec = 1; m_gnt = 0; end
    end else if (!m_sec) begin
      if (!m_perm) begin
        if (quiet_now) begin m_perm = 1; m_pulse = 1; end
      end else if (local_done) m_active = 0;
    end else begin
      if (sec_req_n) begin m_active = 0; m_gnt = 0; end
      else if (!idle_gnt_n) m_gnt = 1;
    end
  endtask

  task automatic compare(input string tag);
    logic [2:0] got, exp;
    got = {idle_req_n, sec_gnt_n, connect_ok};
    exp = expect_outs();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {idle_req_n,sec_gnt_n,connect_ok} actual %b expected %b at %0t",
               tag, got, exp, $time);
    end
  endtask

  // inputs are set; clock one edge and check at the following falling edge
  task automatic step(input string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic drive(input logic lr, input logic ld, input logic sr,
                       input logic gn, input logic fr, input logic ir);
    local_req = lr; local_done = ld; sec_req_n = sr;
    idle_gnt_n = gn; frame_n = fr; irdy_n = ir;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    drive(0, 0, 1, 1, 1, 1);
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1;
    step("R1 after release");
    // R7: cascade input idle high, grant toggling, nothing requested
    for (int i = 0; i < 4; i++) begin
      drive(0, 0, 1, i[0], i[1], 1);
      step("R7 high secondary request");
    end
    // R2 local request
    drive(1, 0, 1, 1, 1, 1);
    step("R2 local request");
    drive(0, 0, 1, 1, 1, 1);
    step("R5 no grant no permit");
    drive(0, 0, 1, 0, 0, 1);
    step("R5 frame busy no permit");
    drive(0, 0, 1, 0, 1, 0);
    step("R5 irdy busy no permit");
    drive(0, 1, 1, 0, 1, 1);
    step("R3 permit after idle");
    drive(0, 0, 1, 0, 1, 1);
    step("R4 permit single cycle");
    drive(0, 1, 1, 0, 1, 1);
    step("R10 done ends handshake");
    // R9 simultaneous requests, grant already low
    drive(1, 0, 0, 0, 1, 1);
    step("R9 local wins");
    drive(0, 0, 0, 0, 1, 1);
    step("R12 permit without secondary grant");
    drive(0, 1, 0, 0, 1, 1);
    step("R9 secondary held off");
    drive(0, 0, 0, 1, 1, 1);
    step("R6 secondary request forwarded");
    step("R8 no grant yet");
    drive(0, 0, 0, 0, 1, 1);
    step("R8 grant passed down");
    drive(0, 0, 1, 0, 1, 1);
    step("R11 secondary grant drop");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom % 8) == 0, ($urandom % 4) == 0, ($urandom % 5) != 0,
            ($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0);
      step("R3 R8 R9 R11 random model");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule